// File: doc/BRIEF.md
# Paged Program Counter and Instruction Sequencer

This block produces the instruction address and the four timing strobes of each instruction for a small Harvard-style 8-bit machine that runs one instruction per fixed sequence of four clock phases. The 18-bit code address is made of three parts. An 8-bit page register forms the upper bits. A single flag bit sits below it. A 9-bit low counter forms the bottom bits. Only the low counter advances, by one per instruction, so a program runs inside a 512-instruction page until it is moved somewhere else.

The address cannot be loaded as one value. The page register and the flag bit accept new data. The low counter can only count up or be cleared. A plain page load changes the page and lets the low counter keep counting. A page load with clear also sets the low counter to zero, which acts as a far jump to the start of a page. A periodic tick, when interrupts are enabled, is held as pending and then clears the whole address to zero at the next instruction boundary.

Top module: `code_sequencer`

## Requirements
- R1: While `rst_n` is low, `code_addr` is 0, `ph_addr` is 1 and the other three strobes are 0.
- R2: Exactly one strobe is high in every cycle. The strobes follow the order `ph_addr`, `ph_fetch`, `ph_bus`, `ph_write` and then repeat, one phase per clock.
- R3: `code_addr` is {page[7:0], flag, low[8:0]}, with the flag at bit 9. It changes only at the clock edge that ends a `ph_write` cycle. At that edge `low` increases by one unless another requirement says otherwise.
- R4: When `low` steps from 511 to 0, the page and the flag keep their values.
- R5: `page_ld` high during `ph_write` loads `page_d` into the page at the end of that cycle. The low counter still increments.
- R6: `page_ld_clr` high during `ph_write` loads `page_d` into the page and sets `low` to 0 at the end of that cycle. The clear takes priority over the increment.
- R7: `flag_ld` high during `ph_write` loads `flag_d` into address bit 9 at the end of that cycle.
- R8: `page_ld`, `page_ld_clr` and `flag_ld` have no effect in the `ph_addr`, `ph_fetch` and `ph_bus` cycles.
- R9: A `tick` pulse seen while `irq_en` is high is held as pending. At the end of the next `ph_write` cycle it clears the whole address to 0. This takes priority over any load or increment in that instruction, and the pending state is then cleared.
- R10: While `irq_en` is low, `tick` is ignored and any pending tick is dropped. Raising `irq_en` later does not clear the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| page_ld | input | 1 | Load page from `page_d` |
| page_ld_clr | input | 1 | Load page from `page_d` and clear low counter |
| page_d | input | 8 | New page value |
| flag_ld | input | 1 | Load flag bit from `flag_d` |
| flag_d | input | 1 | New flag value |
| tick | input | 1 | Periodic interrupt tick, one-cycle pulse |
| irq_en | input | 1 | Interrupt enable |
| code_addr | output | 18 | Instruction address {page, flag, low} |
| ph_addr | output | 1 | Phase strobe: address ready |
| ph_fetch | output | 1 | Phase strobe: instruction fetch |
| ph_bus | output | 1 | Phase strobe: bus and data address ready |
| ph_write | output | 1 | Phase strobe: write |

## Verification
The properties assume that `tick` is a synchronous pulse and that the load strobes are only meaningful when sampled on a clock edge. They also assume that `page_d` is held valid in any cycle where a page load is raised. The stimulus changes every input on the falling edge. It raises `tick` for a single cycle at the start of an instruction and holds `irq_en` constant for a whole instruction. One directed case raises the load strobes only in the first three phases, to show that they are ignored there.

// File: rtl/code_sequencer.sv
module code_sequencer #(
  parameter int PAGE_W = 8,
  parameter int LOW_W  = 9,
  localparam int ADDR_W = PAGE_W + 1 + LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_ld,
  input  logic              page_ld_clr,
  input  logic [PAGE_W-1:0] page_d,
  input  logic              flag_ld,
  input  logic              flag_d,
  input  logic              tick,
  input  logic              irq_en,
  output logic [ADDR_W-1:0] code_addr,
  output logic              ph_addr,
  output logic              ph_fetch,
  output logic              ph_bus,
  output logic              ph_write
);

  logic [1:0]        ph;
  logic [PAGE_W-1:0] page;
  logic              flag;
  logic [LOW_W-1:0]  low;
  logic              pend;

  wire last = (ph == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      page <= '0;
      flag <= 1'b0;
      low  <= '0;
      pend <= 1'b0;
    end else begin
      ph   <= ph + 2'd1;
      pend <= irq_en & (tick | (pend & ~last));
      if (last) begin
        if (pend) begin
          page <= '0;
          flag <= 1'b0;
          low  <= '0;
        end else begin
          if (page_ld | page_ld_clr) page <= page_d;
          if (flag_ld) flag <= flag_d;
          low <= page_ld_clr ? '0 : low + 1'b1;
        end
      end
    end
  end

  assign code_addr = {page, flag, low};
  assign ph_addr   = (ph == 2'd0);
  assign ph_fetch  = (ph == 2'd1);
  assign ph_bus    = (ph == 2'd2);
  assign ph_write  = last;

endmodule

// File: rtl/code_sequencer_chk.sv
module code_sequencer_chk #(
  parameter int PAGE_W = 8,
  parameter int LOW_W  = 9,
  localparam int ADDR_W = PAGE_W + 1 + LOW_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_ld,
  input logic              page_ld_clr,
  input logic [PAGE_W-1:0] page_d,
  input logic              flag_ld,
  input logic              irq_en,
  input logic              pend,
  input logic [LOW_W-1:0]  low,
  input logic [ADDR_W-1:0] code_addr,
  input logic              ph_addr,
  input logic              ph_fetch,
  input logic              ph_bus,
  input logic              ph_write
);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ph_addr, ph_fetch, ph_bus, ph_write}) == 1);

  a_r2_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
    ph_write |=> ph_addr);

  a_r2_next_order: assert property (@(posedge clk) disable iff (!rst_n)
    ph_addr |=> ph_fetch);

  a_r3_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_write |=> $stable(code_addr));

  a_r4_wrap_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_write && !pend && !page_ld && !page_ld_clr && !flag_ld && (low == '1))
    |=> (low == '0) && $stable(code_addr[ADDR_W-1:LOW_W]));

  a_r6_far_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_write && !pend && page_ld_clr)
    |=> (low == '0) && (code_addr[ADDR_W-1:LOW_W+1] == $past(page_d)));

  a_r9_irq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_write && pend) |=> (code_addr == '0));

  a_r10_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !pend);

endmodule

bind code_sequencer code_sequencer_chk #(.PAGE_W(PAGE_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_ld_clr(page_ld_clr),
  .page_d(page_d), .flag_ld(flag_ld), .irq_en(irq_en), .pend(pend), .low(low),
  .code_addr(code_addr), .ph_addr(ph_addr), .ph_fetch(ph_fetch),
  .ph_bus(ph_bus), .ph_write(ph_write)
);

// File: tb/code_sequencer_tb.sv
module code_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page_ld = 0, page_ld_clr = 0, flag_ld = 0, flag_d = 0, tick = 0, irq_en = 0;
  logic [7:0] page_d = '0;
  logic [17:0] code_addr;
  logic ph_addr, ph_fetch, ph_bus, ph_write;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  code_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .page_ld(page_ld), .page_ld_clr(page_ld_clr),
    .page_d(page_d), .flag_ld(flag_ld), .flag_d(flag_d), .tick(tick),
    .irq_en(irq_en), .code_addr(code_addr), .ph_addr(ph_addr),
    .ph_fetch(ph_fetch), .ph_bus(ph_bus), .ph_write(ph_write)
  );

  // entry: {pl, plc, pd[7:0], fl, fd, tk, ie, expected_addr[17:0]}
  localparam logic [31:0] TBL [10] = '{
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 18'h00001},  // R3 increment
    {1'b1,1'b0,8'h5A,1'b0,1'b0,1'b0,1'b0, 18'h16802},  // R5 page load
    {1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0, 18'h16A03},  // R7 flag set
    {1'b0,1'b1,8'h03,1'b0,1'b0,1'b0,1'b0, 18'h00E00},  // R6 far jump
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 18'h00E01},  // R3
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0, 18'h00E02},  // R10 tick ignored
    {1'b1,1'b0,8'hFF,1'b0,1'b0,1'b1,1'b1, 18'h00000},  // R9 irq beats load
    {1'b1,1'b0,8'h80,1'b1,1'b1,1'b0,1'b0, 18'h20201},  // R5 R7 together
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 18'h20002},  // R7 flag clear
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 18'h20003}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at the falling edge that starts ph_addr; returns at the next one.
  task automatic do_instr(input logic [13:0] v, input bit early);
    logic [17:0] start;
    start = code_addr;
    for (int k = 0; k < 4; k++) begin
      bit on;
      on = early ? (k < 3) : (k == 3);
      page_ld     = on & v[13];
      page_ld_clr = on & v[12];
      page_d      = v[11:4];
      flag_ld     = on & v[3];
      flag_d      = v[2];
      tick        = (k == 0) & v[1];
      irq_en      = v[0];
      check("R2", {28'd0, ph_write, ph_bus, ph_fetch, ph_addr}, 32'd1 << k);
      check("R3", {14'd0, code_addr}, {14'd0, start});
      @(negedge clk);
    end
    page_ld = 0; page_ld_clr = 0; flag_ld = 0; tick = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {14'd0, code_addr}, 32'd0);
    check("R1", {28'd0, ph_write, ph_bus, ph_fetch, ph_addr}, 32'd1);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      do_instr(TBL[i][31:18], 1'b0);
      check("R3 R5 R6 R7 R9 R10 table", {14'd0, code_addr}, {14'd0, TBL[i][17:0]});
    end

    // R6 far jump with flag set, then run to the end of the page
    do_instr({1'b0,1'b1,8'h11,1'b1,1'b1,1'b0,1'b0}, 1'b0);
    check("R6", {14'd0, code_addr}, 32'h04600);
    for (int n = 0; n < 511; n++) do_instr(14'd0, 1'b0);
    check("R4", {14'd0, code_addr}, 32'h047FF);
    do_instr(14'd0, 1'b0);
    check("R4", {14'd0, code_addr}, 32'h04600);

    // R8 loads outside the write phase are ignored
    do_instr({1'b1,1'b1,8'hAA,1'b1,1'b0,1'b0,1'b0}, 1'b1);
    check("R8", {14'd0, code_addr}, 32'h04601);

    // R10 tick with irq off, then irq on with no tick
    do_instr({1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0}, 1'b0);
    check("R10", {14'd0, code_addr}, 32'h04602);
    do_instr({1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1}, 1'b0);
    check("R10", {14'd0, code_addr}, 32'h04603);

    // R9 tick with irq on beats a far jump; pending is cleared afterwards
    do_instr({1'b0,1'b1,8'h42,1'b0,1'b0,1'b1,1'b1}, 1'b0);
    check("R9", {14'd0, code_addr}, 32'h0);
    do_instr({1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1}, 1'b0);
    check("R9 cleared", {14'd0, code_addr}, 32'h1);

    // R1 reset in mid run
    do_instr({1'b1,1'b0,8'h7E,1'b0,1'b0,1'b0,1'b0}, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {14'd0, code_addr}, 32'd0);
    check("R1", {28'd0, ph_write, ph_bus, ph_fetch, ph_addr}, 32'd1);
    rst_n = 1'b1;
    do_instr(14'd0, 1'b0);
    check("R3", {14'd0, code_addr}, 32'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule